// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a parameterised register (eight bits by default) that, on each rising clock edge, keeps its value, moves every bit one place toward the most significant end, moves every bit one place toward the least significant end, or captures a whole word from a shared parallel bus. A synchronous active-low clear overrides the two select bits. Each end of the register has its own serial input, and the two end bits leave on their own always-driven serial outputs, so several instances can be chained into a longer shift path.

The parallel bus is shared between input and output and is modelled as three signals: an input word, an output word and a single drive-enable. The drive-enable is high only when both active-low enable inputs are low and the select code is not the load code. The register keeps working whether or not the bus is driven.

Top module: `usr_bidir_shreg`

## Requirements
- R1: With `clr_n` high and `sel` = 2'b00, the register keeps its value across the clock edge.
- R2: With `clr_n` high and `sel` = 2'b01 (`sel[0]` high), each bit i moves into bit i+1 and `ser_lo_in` enters bit 0.
- R3: With `clr_n` high and `sel` = 2'b10 (`sel[1]` high), each bit i moves into bit i-1 and `ser_hi_in` enters the most significant bit.
- R4: With `clr_n` high and `sel` = 2'b11, the register takes the value of `pin_in` at the clock edge.
- R5: With `clr_n` low at a rising edge, every bit becomes 0 whatever `sel` holds.
- R6: `pin_oe` is 1 exactly when `oe_a_n` and `oe_b_n` are both 0 and `sel` is not 2'b11; it follows its inputs without a clock.
- R7: Hold, both shifts, load and clear behave the same whether `pin_oe` is 0 or 1.
- R8: `tap_lo_out` always equals register bit 0 and `tap_hi_out` the most significant bit, whatever the enables.
- R9: `pin_out` always carries the register value, whether or not it is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| sel | input | 2 | Operation select: 00 keep, 01 move up, 10 move down, 11 load |
| ser_lo_in | input | 1 | Serial bit entering bit 0 on an upward move |
| ser_hi_in | input | 1 | Serial bit entering the top bit on a downward move |
| oe_a_n | input | 1 | Bus drive enable, active low |
| oe_b_n | input | 1 | Second bus drive enable, active low |
| pin_in | input | WIDTH | Value seen on the shared bus, captured on load |
| pin_out | output | WIDTH | Register value presented to the shared bus |
| pin_oe | output | 1 | Shared bus driver enable |
| tap_lo_out | output | 1 | Bit 0 for chaining |
| tap_hi_out | output | 1 | Top bit for chaining |

## Verification
Directed sequences load a known alternating word and then push ones and zeros in from each end, so that the two shift directions and the entry bit at each end are told apart by where the pattern ends up. A clear issued together with the load code shows that clearing wins over loading. A long random run mixes all four select codes, clear pulses and all enable pairs, so that bus-disabled operation and the load-forced driver shut-off are both seen with every operation.

// File: rtl/usr_pkg.sv
package usr_pkg;
   localparam logic [1:0] SEL_KEEP = 2'b00;
   localparam logic [1:0] SEL_UP   = 2'b01;
   localparam logic [1:0] SEL_DOWN = 2'b10;
   localparam logic [1:0] SEL_LOAD = 2'b11;

   typedef enum logic [2:0] {
      OP_KEEP,
      OP_UP,
      OP_DOWN,
      OP_LOAD,
      OP_CLEAR
   } op_e;
endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
   import usr_pkg::*;
(
   input  logic       clr_n,
   input  logic [1:0] sel,
   output op_e        op,
   output logic       load_code
);
   always_comb begin
      load_code = (sel == SEL_LOAD);
      if (!clr_n) begin
         op = OP_CLEAR;
      end else begin
         unique case (sel)
            SEL_UP:   op = OP_UP;
            SEL_DOWN: op = OP_DOWN;
            SEL_LOAD: op = OP_LOAD;
            default:  op = OP_KEEP;
         endcase
      end
   end

   // R5
   always_comb begin
      clear_wins_chk: assert (clr_n || op == OP_CLEAR);
   end
endmodule

// File: rtl/usr_bit_slice.sv
module usr_bit_slice
   import usr_pkg::*;
(
   input  op_e  op,
   input  logic cur,
   input  logic from_below,
   input  logic from_above,
   input  logic par_in,
   output logic nxt
);
   always_comb begin
      unique case (op)
         OP_CLEAR: nxt = 1'b0;
         OP_UP:    nxt = from_below;
         OP_DOWN:  nxt = from_above;
         OP_LOAD:  nxt = par_in;
         default:  nxt = cur;
      endcase
   end
endmodule

// File: rtl/usr_port_ctl.sv
module usr_port_ctl #(
   parameter int unsigned N_EN = 2
) (
   input  logic [N_EN-1:0] en_n,
   input  logic            load_code,
   output logic            pin_oe
);
   always_comb begin
      pin_oe = ~(|en_n) & ~load_code;
   end

   // R6
   always_comb begin
      load_shuts_bus_chk: assert (!(load_code && pin_oe));
   end
endmodule

// File: rtl/usr_bidir_shreg.sv
module usr_bidir_shreg
   import usr_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [1:0]       sel,
   input  logic             ser_lo_in,
   input  logic             ser_hi_in,
   input  logic             oe_a_n,
   input  logic             oe_b_n,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic             pin_oe,
   output logic             tap_lo_out,
   output logic             tap_hi_out
);
   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("usr_bidir_shreg: WIDTH must be at least 2");
   end

   op_e              op;
   logic             load_code;
   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] q_nxt;

   usr_mode_dec u_dec (
      .clr_n     (clr_n),
      .sel       (sel),
      .op        (op),
      .load_code (load_code)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic below;
      logic above;
      if (i == 0) begin : g_lo
         assign below = ser_lo_in;
      end else begin : g_lo
         assign below = q[i-1];
      end
      if (i == MSB) begin : g_hi
         assign above = ser_hi_in;
      end else begin : g_hi
         assign above = q[i+1];
      end
      usr_bit_slice u_slice (
         .op         (op),
         .cur        (q[i]),
         .from_below (below),
         .from_above (above),
         .par_in     (pin_in[i]),
         .nxt        (q_nxt[i])
      );
   end

   always_ff @(posedge clk) begin
      q <= q_nxt;
   end

   usr_port_ctl #(.N_EN(2)) u_port (
      .en_n      ({oe_b_n, oe_a_n}),
      .load_code (load_code),
      .pin_oe    (pin_oe)
   );

   assign pin_out    = q;
   assign tap_lo_out = q[0];
   assign tap_hi_out = q[MSB];

   // R1
   keep_stable_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (sel == SEL_KEEP) |=> $stable(pin_out));
   // R2
   move_up_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (sel == SEL_UP) |=> (pin_out == {$past(pin_out[MSB-1:0]), $past(ser_lo_in)}));
   // R3
   move_down_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (sel == SEL_DOWN) |=> (pin_out == {$past(ser_hi_in), $past(pin_out[MSB:1])}));
   // R4
   load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (sel == SEL_LOAD) |=> (pin_out == $past(pin_in)));
   // R5
   clear_zero_chk: assert property (@(posedge clk)
      !clr_n |=> (pin_out == '0));
   // R8
   taps_follow_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (tap_lo_out == pin_out[0]) && (tap_hi_out == pin_out[MSB]));
endmodule

// File: tb/usr_bidir_shreg_tb.sv
module usr_bidir_shreg_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         clr_n, ser_lo_in, ser_hi_in, oe_a_n, oe_b_n;
   logic [1:0]   sel;
   logic [W-1:0] pin_in, pin_out;
   logic         pin_oe, tap_lo_out, tap_hi_out;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   bit          done  = 1'b0;
   logic [W-1:0] exp_q;

   always #2 clk = ~clk;

   usr_bidir_shreg #(.WIDTH(W)) u_dut (
      .clk(clk), .clr_n(clr_n), .sel(sel), .ser_lo_in(ser_lo_in),
      .ser_hi_in(ser_hi_in), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .tap_lo_out(tap_lo_out), .tap_hi_out(tap_hi_out)
   );

   function automatic logic [W-1:0] model_next(logic [W-1:0] cur, logic c_n,
      logic [1:0] s, logic lo, logic hi, logic [W-1:0] d);
      if (!c_n)          return '0;
      if (s == 2'b01)    return {cur[W-2:0], lo};
      if (s == 2'b10)    return {hi, cur[W-1:1]};
      if (s == 2'b11)    return d;
      return cur;
   endfunction

   function automatic logic model_oe(logic a, logic b, logic [1:0] s);
      return !a && !b && (s != 2'b11);
   endfunction

   function automatic string req_of(logic c_n, logic [1:0] s, logic a, logic b);
      string r;
      if (!c_n)            r = "R5";
      else if (s == 2'b00) r = "R1";
      else if (s == 2'b01) r = "R2";
      else if (s == 2'b10) r = "R3";
      else                 r = "R4";
      if (a || b || s == 2'b11) r = {r, "/R7"};
      return r;
   endfunction

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(logic c_n, logic [1:0] s, logic lo, logic hi,
                       logic a, logic b, logic [W-1:0] d);
      string r;
      @(negedge clk);
      clr_n = c_n; sel = s; ser_lo_in = lo; ser_hi_in = hi;
      oe_a_n = a; oe_b_n = b; pin_in = d;
      #1;
      check("R6", {{(W-1){1'b0}}, pin_oe}, {{(W-1){1'b0}}, model_oe(a, b, s)});
      r = req_of(c_n, s, a, b);
      exp_q = model_next(exp_q, c_n, s, lo, hi, d);
      @(posedge clk);
      #1;
      check({r, "/R9"}, pin_out, exp_q);
      check("R8", {{(W-2){1'b0}}, tap_hi_out, tap_lo_out},
            {{(W-2){1'b0}}, exp_q[W-1], exp_q[0]});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1357));
      clr_n = 1'b0; sel = 2'b11; ser_lo_in = 1'b0; ser_hi_in = 1'b0;
      oe_a_n = 1'b0; oe_b_n = 1'b0; pin_in = 8'hFF;
      exp_q = '0;
      // R5: clear while load code is present, reset state
      step(1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF);
      // R4 with bus disabled (R7)
      step(1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5);
      // R1 hold, bus enabled and a new pin_in value ignored
      step(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C);
      step(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
      // R2: ones in from the low end
      for (int i = 0; i < 3; i++) step(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      // R3: zeros then ones from the high end, bus off (R7)
      for (int i = 0; i < 4; i++) step(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF);
      for (int i = 0; i < 9; i++) step(1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
      // R5 with shift code and bus enabled
      step(1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF);
      // R4 boundary: all ones, then a single walking bit up to the top
      step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
      step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
      for (int i = 0; i < W; i++) step(1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
      // mixed random run
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] pick;
         pick = 4'($urandom_range(0, 15));
         step(pick != 4'd0, 2'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 8'($urandom));
      end
      finish_run();
   end
endmodule